// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Controller

This block is a bus-attached peripheral that gives a host three 8-bit general-purpose ports, called A, B and C, plus one control register. The host reaches all four through a small synchronous register interface. Each cycle it presents an address, write data and a write strobe. Read data and an address-error flag come back combinationally for the address being presented. The control word sets the direction of port A, of port B, and of each nibble of port C separately.

A control write with its top bit clear does not touch the control register. It is instead a command that sets or clears one chosen bit of the port C latch. This lets software toggle a single port C line without a read-modify-write.

Each port drives an 8-bit output bus and an 8-bit per-bit output-enable bus, so a tri-state pad wrapper can sit outside the block. Pin levels come back on input buses. They pass through a configurable synchronizer before a read can see them. Only plain input/output operation is provided.

Top module: `tri_port_pio`

## Requirements
- R1: While reset is asserted and right after it, the three port latches hold 0x00 and the control register holds 0x9B. Every port and nibble is then in input mode, with all outputs and output enables at 0.
- R2: Addresses 0, 1, 2 and 3 select latch A, latch B, latch C and the control register. Any address of 4 or above raises `addr_err` in that cycle and reads 0x00. A write to such an address changes no register.
- R3: A write to address 3 with bit 7 = 1 stores the whole byte as the new control word. The three port latches keep their contents.
- R4: A write to address 3 with bit 7 = 0 leaves the control register unchanged. Bits 3:1 give a port C bit index from 0 to 7, and bit 0 gives the value loaded into that one latch bit (1 sets, 0 clears). All other port C latch bits keep their values.
- R5: The direction bits in the control word are: bit 4 for port A, bit 1 for port B, bit 0 for port C bits 3:0, and bit 3 for port C bits 7:4. A direction bit of 1 means input. Each output-enable bit is the inverse of the direction bit that covers it.
- R6: A port or nibble in input mode drives 0 on its output lines. In output mode it drives its latch contents.
- R7: Reading address 0, 1 or 2 returns the synchronized pin value for a port or nibble in input mode, and the latch value for one in output mode. The two nibbles of port C are chosen independently.
- R8: Reading address 3 returns the current control register.
- R9: A latch or control write changes the port outputs at the same clock edge that stores it, so the new output is visible in the cycle after the strobe.
- R10: A pin change becomes visible to reads after exactly `SYNC_STAGES` rising clock edges (default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (3) | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for the current address |
| addr_err | output | 1 | High when the address is out of range |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output levels |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output levels |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output levels |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
Latches are written while every port is still an input and read back after switching to all-output. This separates direction masking from latch storage and shows that a mode write does not clear data. Mixed words such as 0x81, 0x88 and 0x92 put one port C nibble, or one whole port, on the pins while the others read latches, which exposes any swap of direction bit positions. Single-bit commands at indices 0 and 7 catch an off-by-one in the index field or a stray change to the control word. A stepped pin change counts the synchronizer latency, and a long pseudo-random run of writes, mode words and pin values is compared against the bench model on every cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;

    typedef logic [PORT_W-1:0] pbyte_t;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // control word bit positions
    localparam int MODE_FLAG_BIT = 7;
    localparam int DIR_A_BIT     = 4;
    localparam int DIR_CH_BIT    = 3;
    localparam int DIR_B_BIT     = 1;
    localparam int DIR_CL_BIT    = 0;

    typedef struct packed {
        pbyte_t pa;
        pbyte_t pb;
        pbyte_t pc;
        pbyte_t ctrl;
    } pio_regs_t;

endpackage

// File: rtl/pio_insync.sv
module pio_insync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign dout = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
#(
    parameter logic [7:0] CTRL_RST = 8'h9B
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      addr_ok,
    input  sel_e      sel,
    input  logic      wr_en,
    input  pbyte_t    wdata,
    output pio_regs_t regs_q
);

    pio_regs_t regs_d;
    logic      bit_cmd;
    logic [2:0] bit_idx;

    assign bit_cmd = !wdata[MODE_FLAG_BIT];
    assign bit_idx = wdata[3:1];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && addr_ok) begin
            unique case (sel)
                SEL_A: regs_d.pa = wdata;
                SEL_B: regs_d.pb = wdata;
                SEL_C: regs_d.pc = wdata;
                SEL_CTRL: begin
                    if (bit_cmd) regs_d.pc[bit_idx] = wdata[0];
                    else         regs_d.ctrl        = wdata;
                end
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.pa   <= '0;
            regs_q.pb   <= '0;
            regs_q.pc   <= '0;
            regs_q.ctrl <= CTRL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R3: a mode word is stored whole
    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && sel == SEL_CTRL && wdata[MODE_FLAG_BIT])
        |=> (regs_q.ctrl == $past(wdata)));

    // R3: a mode word keeps the latches
    p_latch_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && sel == SEL_CTRL && wdata[MODE_FLAG_BIT])
        |=> ({regs_q.pa, regs_q.pb, regs_q.pc} == $past({regs_q.pa, regs_q.pb, regs_q.pc})));

    // R4: bit command leaves control word alone
    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && sel == SEL_CTRL && !wdata[MODE_FLAG_BIT])
        |=> $stable(regs_q.ctrl));

    // R4: bit command moves at most one port C bit, the addressed one
    p_pc_onebit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && sel == SEL_CTRL && !wdata[MODE_FLAG_BIT])
        |=> ($countones(regs_q.pc ^ $past(regs_q.pc)) <= 1
             && regs_q.pc[$past(wdata[3:1])] == $past(wdata[0])));

    // R2: out-of-range write changes nothing
    p_bad_wr_noeffect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_ok) |=> $stable(regs_q));

endmodule

// File: rtl/pio_lane.sv
module pio_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pin_sync,
    input  logic         is_input,
    output logic [W-1:0] out,
    output logic [W-1:0] oe,
    output logic [W-1:0] rd
);

    always_comb begin
        if (is_input) begin
            out = '0;
            oe  = '0;
            rd  = pin_sync;
        end else begin
            out = latch;
            oe  = '1;
            rd  = latch;
        end
    end

endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import pio_pkg::*;
#(
    parameter int         ADDR_W      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CTRL_RST    = 8'h9B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    output logic [7:0]        rdata,
    output logic              addr_err,
    input  logic [7:0]        pa_in,
    output logic [7:0]        pa_out,
    output logic [7:0]        pa_oe,
    input  logic [7:0]        pb_in,
    output logic [7:0]        pb_out,
    output logic [7:0]        pb_oe,
    input  logic [7:0]        pc_in,
    output logic [7:0]        pc_out,
    output logic [7:0]        pc_oe
);

    localparam int PINS_W = 3 * PORT_W;

    logic       addr_ok;
    sel_e       sel;
    pio_regs_t  regs_q;
    logic [PINS_W-1:0] pins_sync;
    pbyte_t     sa, sb, sc;
    pbyte_t     rd_a, rd_b, rd_c;

    generate
        if (ADDR_W > 2) begin : g_addr_chk
            assign addr_ok = ~|addr[ADDR_W-1:2];
        end else begin : g_addr_full
            assign addr_ok = 1'b1;
        end
    endgenerate

    assign sel      = sel_e'(addr[1:0]);
    assign addr_err = !addr_ok;

    pio_insync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pc_in, pb_in, pa_in}),
        .dout (pins_sync)
    );

    assign {sc, sb, sa} = pins_sync;

    pio_regfile #(.CTRL_RST(CTRL_RST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_ok(addr_ok),
        .sel    (sel),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .regs_q (regs_q)
    );

    pio_lane #(.W(PORT_W)) u_lane_a (
        .latch(regs_q.pa), .pin_sync(sa), .is_input(regs_q.ctrl[DIR_A_BIT]),
        .out(pa_out), .oe(pa_oe), .rd(rd_a)
    );

    pio_lane #(.W(PORT_W)) u_lane_b (
        .latch(regs_q.pb), .pin_sync(sb), .is_input(regs_q.ctrl[DIR_B_BIT]),
        .out(pb_out), .oe(pb_oe), .rd(rd_b)
    );

    pio_lane #(.W(NIB_W)) u_lane_cl (
        .latch(regs_q.pc[NIB_W-1:0]), .pin_sync(sc[NIB_W-1:0]),
        .is_input(regs_q.ctrl[DIR_CL_BIT]),
        .out(pc_out[NIB_W-1:0]), .oe(pc_oe[NIB_W-1:0]), .rd(rd_c[NIB_W-1:0])
    );

    pio_lane #(.W(NIB_W)) u_lane_ch (
        .latch(regs_q.pc[PORT_W-1:NIB_W]), .pin_sync(sc[PORT_W-1:NIB_W]),
        .is_input(regs_q.ctrl[DIR_CH_BIT]),
        .out(pc_out[PORT_W-1:NIB_W]), .oe(pc_oe[PORT_W-1:NIB_W]), .rd(rd_c[PORT_W-1:NIB_W])
    );

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            unique case (sel)
                SEL_A:    rdata = rd_a;
                SEL_B:    rdata = rd_b;
                SEL_C:    rdata = rd_c;
                SEL_CTRL: rdata = regs_q.ctrl;
                default:  rdata = '0;
            endcase
        end
    end

    // R2: out-of-range address reads zero
    p_bad_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (rdata == 8'h00));

    // R6: no line driven high while its enable is off
    p_out_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_out & ~pa_oe) == 8'h00 && (pb_out & ~pb_oe) == 8'h00 && (pc_out & ~pc_oe) == 8'h00));

    // R5: each nibble's enables move together
    p_oe_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pc_oe[3:0]) inside {0, 4}) && ($countones(pc_oe[7:4]) inside {0, 4}));

    // R9: a port A latch write in output mode shows on the next cycle
    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && sel == SEL_A && pa_oe == 8'hFF) |=> (pa_out == $past(wdata)));

endmodule

// File: tb/tb_tri_port_pio.sv
`timescale 1ns/1ps
module tb_tri_port_pio;

    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic       addr_err;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tri_port_pio #(.ADDR_W(3), .SYNC_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .addr_err(addr_err),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // behavioural reference state
    logic [7:0]  m_pa, m_pb, m_pc, m_ctrl;
    logic [23:0] hist[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] synced();
        if (hist.size() < STG) return 24'h0;
        return hist[hist.size() - STG];
    endfunction

    function automatic logic [7:0] pick(input logic in_mode, input logic [7:0] pin, input logic [7:0] lat);
        return in_mode ? pin : lat;
    endfunction

    task automatic compare_all();
        logic [23:0] s;
        logic [7:0] e_rd, e_pc_out, e_pc_oe, e_rc;
        string rtag;
        s = synced();
        e_rc = {pick(m_ctrl[3], s[23:16], m_pc) & 8'hF0} | (pick(m_ctrl[0], s[23:16], m_pc) & 8'h0F);
        case (addr)
            3'd0: begin e_rd = pick(m_ctrl[4], s[7:0],  m_pa); rtag = "R7 read A"; end
            3'd1: begin e_rd = pick(m_ctrl[1], s[15:8], m_pb); rtag = "R7 read B"; end
            3'd2: begin e_rd = e_rc; rtag = "R7 read C"; end
            3'd3: begin e_rd = m_ctrl; rtag = "R8 read ctrl"; end
            default: begin e_rd = 8'h00; rtag = "R2 read invalid"; end
        endcase
        chk(rtag, rdata, e_rd);
        chk("R2 addr_err", addr_err, addr > 3'd3);
        chk("R6 pa_out", pa_out, m_ctrl[4] ? 8'h00 : m_pa);
        chk("R6 pb_out", pb_out, m_ctrl[1] ? 8'h00 : m_pb);
        e_pc_out = {m_ctrl[3] ? 4'h0 : m_pc[7:4], m_ctrl[0] ? 4'h0 : m_pc[3:0]};
        e_pc_oe  = {m_ctrl[3] ? 4'h0 : 4'hF, m_ctrl[0] ? 4'h0 : 4'hF};
        chk("R6 pc_out", pc_out, e_pc_out);
        chk("R5 pa_oe", pa_oe, m_ctrl[4] ? 8'h00 : 8'hFF);
        chk("R5 pb_oe", pb_oe, m_ctrl[1] ? 8'h00 : 8'hFF);
        chk("R5 pc_oe", pc_oe, e_pc_oe);
    endtask

    // reference model, stepped on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pa = 8'h00; m_pb = 8'h00; m_pc = 8'h00; m_ctrl = 8'h9B;
            hist.delete();
        end else begin
            if (wr_en && addr <= 3'd3) begin
                case (addr)
                    3'd0: m_pa = wdata;
                    3'd1: m_pb = wdata;
                    3'd2: m_pc = wdata;
                    default: begin
                        if (wdata[7]) m_ctrl = wdata;
                        else m_pc[wdata[3:1]] = wdata[0];
                    end
                endcase
            end
            hist.push_back({pc_in, pb_in, pa_in});
            #1;
            if (!done) compare_all();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_at(input logic [2:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        repeat (3) @(negedge clk);
        // R1: reset state
        addr = 3'd3; #1;
        chk("R1 ctrl reset", rdata, 8'h9B);
        chk("R1 outputs zero", {pa_out, pb_out, pc_out}, 24'h0);
        chk("R1 enables zero", {pa_oe, pb_oe, pc_oe}, 24'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // latches written in input mode stay hidden
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33);
        chk("R6 input mode hides latch", pa_out, 8'h00);
        rd_at(3'd0);
        chk("R7 read A pins in input mode", rdata, 8'h5A);

        // R3: mode word keeps latches
        wr(3'd3, 8'h80);
        rd_at(3'd0); chk("R3 latch A kept", rdata, 8'h11);
        rd_at(3'd2); chk("R3 latch C kept", rdata, 8'h33);
        rd_at(3'd3); chk("R3 ctrl stored", rdata, 8'h80);

        // R9: write visible right after its edge
        wr(3'd0, 8'hA5);
        chk("R9 pa_out after write", pa_out, 8'hA5);

        // R4: single-bit commands on port C
        wr(3'd3, 8'h0F);
        chk("R4 set bit 7", pc_out, 8'hB3);
        wr(3'd3, 8'h00);
        chk("R4 clear bit 0", pc_out, 8'hB2);
        rd_at(3'd3); chk("R4 ctrl unchanged", rdata, 8'h80);

        // R5/R7: mixed directions
        wr(3'd3, 8'h81);
        rd_at(3'd2); chk("R7 C low from pins", rdata, 8'hB6);
        chk("R5 C low oe off", pc_oe, 8'hF0);
        wr(3'd3, 8'h88);
        rd_at(3'd2); chk("R7 C high from pins", rdata, 8'h92);
        wr(3'd3, 8'h92);
        rd_at(3'd1); chk("R7 B from pins", rdata, 8'hC3);
        chk("R5 A oe off", pa_oe, 8'h00);

        // R10: synchronizer latency, A is input
        @(negedge clk); addr = 3'd0; pa_in = 8'h3C;
        @(negedge clk); #1; chk("R10 one edge old value", rdata, 8'h5A);
        @(negedge clk); #1; chk("R10 two edges new value", rdata, 8'h3C);

        // R2: invalid address
        wr(3'd5, 8'hFF);
        rd_at(3'd5); chk("R2 err flag", addr_err, 1'b1); chk("R2 rdata zero", rdata, 8'h00);
        rd_at(3'd3); chk("R2 ctrl untouched", rdata, 8'h92);
        rd_at(3'd2); chk("R2 latch C untouched", rdata, 8'hB2);

        // pseudo-random traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            addr  = lfsr[2:0];
            wdata = lfsr[15:8] ^ lfsr[7:0];
            wr_en = lfsr[3];
            if (lfsr[4]) pa_in = lfsr[11:4];
            if (lfsr[5]) pb_in = lfsr[13:6];
            if (lfsr[6]) pc_in = lfsr[15:8];
        end
        @(negedge clk); wr_en = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule